// File: doc/BRIEF.md
# Triple-Adjacent-Detecting SEC-DED Codec

This block protects a 16-bit memory word with a 6-bit check field. The encoder side turns a data word into a 22-bit codeword. The decoder side takes a codeword read back from storage and does three things. It repairs any one flipped bit. It flags any two flipped bits as uncorrectable. It also flags as uncorrectable any burst of three flips on neighbouring codeword positions. Such bursts are typical when one particle strike upsets several adjacent cells.

The check field is no wider than a plain single-correct, double-detect code of the same data width needs. The extra burst coverage comes only from the choice and ordering of the check-matrix columns. Every column has odd weight. No sum of three neighbouring columns equals any column. A burst therefore always lands on an odd syndrome that no single error could produce.

Both paths have one register stage. The uncorrectable flag is meant to drive an external exception handler. The corrected flag reports a repair that the codec made without help.

Top module: `tae_secded_codec`

## Requirements
- R1: Codeword bits [21:6] carry the data word unchanged and bits [5:0] carry check bits. Check bit k is the XOR of every data bit j whose column has bit k set. The data columns for j = 0..15, in hex, are 0B, 13, 25, 29, 32, 26, 2A, 31, 2C, 1A, 19, 34, 16, 15, 0D, 23. The column of check position k (0..5) is the one-hot value 1<<k.
- R2: A codeword with no error is decoded to its data field, with both flags low.
- R3: A codeword with exactly one flipped bit, at any of the 22 positions, is decoded to the original data. The corrected flag is high and the uncorrectable flag is low.
- R4: A codeword with any two distinct flipped bits raises the uncorrectable flag and leaves the corrected flag low.
- R5: A codeword with three flipped bits at positions p, p+1 and p+2, for any p from 0 to 19, raises the uncorrectable flag and leaves the corrected flag low.
- R6: Encoder and decoder each have one cycle of latency. An output valid goes high in the cycle after its input valid was high.
- R7: While the synchronous active-high reset is high, all outputs are driven to zero at the next clock edge, whatever the inputs.
- R8: In the cycle after a cycle with the decoder input valid low, the decoder output valid and both flags are low, and the decoded data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Data word to encode is present |
| enc_data_i | input | 16 | Data word to encode |
| enc_valid_o | output | 1 | Encoded codeword is valid |
| enc_code_o | output | 22 | Encoded codeword, data in [21:6], checks in [5:0] |
| dec_valid_i | input | 1 | Codeword to decode is present |
| dec_code_i | input | 22 | Codeword read back from storage |
| dec_valid_o | output | 1 | Decoder result is valid |
| dec_data_o | output | 16 | Decoded, repaired data word |
| dec_fixed_o | output | 1 | A single-bit error was repaired |
| dec_fatal_o | output | 1 | Uncorrectable error detected; handler trigger |

## Verification
On every cycle the assertions enforce the one-cycle latency of both paths and the mutual exclusion of the two flags. They also check that a decode never alters more than one data bit, that a zero syndrome passes the data through untouched, and that idle cycles leave the flags low. Inside the classifier they require at most one column match, and a match only on an odd syndrome. Whether each error pattern is put in the right class can only be shown by the bench's scenarios. These cover every single, every double and every adjacent triple, against encoder outputs worked out from the column table.

// File: rtl/tae_secded_pkg.sv
package tae_secded_pkg;

  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int CODE_W = DATA_W + CHK_W;

  // Data columns: all weight 3, ordered so that any three neighbouring
  // codeword columns sum to a weight-5 vector or to an unused weight-3 one.
  function automatic logic [CHK_W-1:0] data_col(input int idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0:       c = 6'h0B;
      1:       c = 6'h13;
      2:       c = 6'h25;
      3:       c = 6'h29;
      4:       c = 6'h32;
      5:       c = 6'h26;
      6:       c = 6'h2A;
      7:       c = 6'h31;
      8:       c = 6'h2C;
      9:       c = 6'h1A;
      10:      c = 6'h19;
      11:      c = 6'h34;
      12:      c = 6'h16;
      13:      c = 6'h15;
      14:      c = 6'h0D;
      15:      c = 6'h23;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Column of a full codeword position: check bits occupy the low end.
  function automatic logic [CHK_W-1:0] code_col(input int pos);
    logic [CHK_W-1:0] one;
    one = CHK_W'(1);
    if (pos < CHK_W) return one << pos;
    return data_col(pos - CHK_W);
  endfunction

endpackage

// File: rtl/tae_secded_enc.sv
module tae_secded_enc #(
  parameter int DATA_W = tae_secded_pkg::DATA_W,
  parameter int CHK_W  = tae_secded_pkg::CHK_W,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CHK_W-1:0] chk;

  always_comb begin
    logic [CHK_W-1:0] col;
    chk = '0;
    for (int j = 0; j < DATA_W; j++) begin
      col = tae_secded_pkg::data_col(j);
      chk = chk ^ (col & {CHK_W{data_i[j]}});
    end
  end

  assign code_o = {data_i, chk};

endmodule

// File: rtl/tae_secded_syn.sv
module tae_secded_syn #(
  parameter int DATA_W = tae_secded_pkg::DATA_W,
  parameter int CHK_W  = tae_secded_pkg::CHK_W,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CHK_W-1:0]  syn_o
);

  always_comb begin
    logic [CHK_W-1:0] col;
    syn_o = '0;
    for (int p = 0; p < CODE_W; p++) begin
      col   = tae_secded_pkg::code_col(p);
      syn_o = syn_o ^ (col & {CHK_W{code_i[p]}});
    end
  end

endmodule

// File: rtl/tae_secded_cls.sv
module tae_secded_cls #(
  parameter int DATA_W = tae_secded_pkg::DATA_W,
  parameter int CHK_W  = tae_secded_pkg::CHK_W,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] flip_o,
  output logic              single_o,
  output logic              fatal_o
);

  logic [CODE_W-1:0] hit;

  genvar p;
  generate
    for (p = 0; p < CODE_W; p++) begin : g_cmp
      assign hit[p] = (syn_i == tae_secded_pkg::code_col(p));
    end
  endgenerate

  assign single_o = |hit;
  assign fatal_o  = (|syn_i) & ~single_o;
  assign flip_o   = hit[CODE_W-1:CHK_W];

  always_comb begin
    p_hit_onehot_r3: assert ($onehot0(hit));
    if (single_o) begin
      p_hit_odd_r4: assert (^syn_i);
    end
  end

endmodule

// File: rtl/tae_secded_codec.sv
module tae_secded_codec (
  input  logic        clk,
  input  logic        rst,
  input  logic        enc_valid_i,
  input  logic [15:0] enc_data_i,
  output logic        enc_valid_o,
  output logic [21:0] enc_code_o,
  input  logic        dec_valid_i,
  input  logic [21:0] dec_code_i,
  output logic        dec_valid_o,
  output logic [15:0] dec_data_o,
  output logic        dec_fixed_o,
  output logic        dec_fatal_o
);

  localparam int DATA_W = tae_secded_pkg::DATA_W;
  localparam int CHK_W  = tae_secded_pkg::CHK_W;
  localparam int CODE_W = tae_secded_pkg::CODE_W;

  logic [CODE_W-1:0] enc_code_w;
  logic [CHK_W-1:0]  syn_w;
  logic [DATA_W-1:0] flip_w;
  logic              single_w;
  logic              fatal_w;
  logic [DATA_W-1:0] fixed_data_w;

  tae_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_w)
  );

  tae_secded_syn #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
    .code_i (dec_code_i),
    .syn_o  (syn_w)
  );

  tae_secded_cls #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_cls (
    .syn_i    (syn_w),
    .flip_o   (flip_w),
    .single_o (single_w),
    .fatal_o  (fatal_w)
  );

  assign fixed_data_w = dec_code_i[CODE_W-1:CHK_W] ^ flip_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
      dec_valid_o <= 1'b0;
      dec_data_o  <= '0;
      dec_fixed_o <= 1'b0;
      dec_fatal_o <= 1'b0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code_w;
      dec_valid_o <= dec_valid_i;
      dec_fixed_o <= dec_valid_i & single_w;
      dec_fatal_o <= dec_valid_i & fatal_w;
      if (dec_valid_i) dec_data_o <= fixed_data_w;
    end
  end

  p_enc_latency_r6: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);

  p_dec_latency_r6: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(dec_fixed_o && dec_fatal_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> (!dec_valid_o && !dec_fixed_o && !dec_fatal_o));

  p_clean_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && syn_w == '0) |=>
      (dec_data_o == $past(dec_code_i[CODE_W-1:CHK_W]) && !dec_fixed_o && !dec_fatal_o));

  p_one_bit_fix_r3: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> ($countones(dec_data_o ^ $past(dec_code_i[CODE_W-1:CHK_W])) <= 1));

endmodule

// File: tb/tae_secded_codec_test.sv
`timescale 1ns/1ps
module tae_secded_codec_test;

  logic        clk;
  logic        rst;
  logic        enc_valid_i;
  logic [15:0] enc_data_i;
  logic        enc_valid_o;
  logic [21:0] enc_code_o;
  logic        dec_valid_i;
  logic [21:0] dec_code_i;
  logic        dec_valid_o;
  logic [15:0] dec_data_o;
  logic        dec_fixed_o;
  logic        dec_fatal_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tae_secded_codec uut (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_fixed_o(dec_fixed_o), .dec_fatal_o(dec_fatal_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // Column table as given in R1.
  function automatic logic [5:0] tb_col(input int j);
    case (j)
      0: return 6'h0B;  1: return 6'h13;  2: return 6'h25;  3: return 6'h29;
      4: return 6'h32;  5: return 6'h26;  6: return 6'h2A;  7: return 6'h31;
      8: return 6'h2C;  9: return 6'h1A; 10: return 6'h19; 11: return 6'h34;
      12: return 6'h16; 13: return 6'h15; 14: return 6'h0D; 15: return 6'h23;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [21:0] tb_encode(input logic [15:0] d);
    logic [5:0] c;
    c = '0;
    for (int j = 0; j < 16; j++) if (d[j]) c = c ^ tb_col(j);
    return {d, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    end
  endtask

  // Drive one codeword, sample the registered result one cycle later.
  task automatic dec_run(input logic [21:0] cw);
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_code_i  = cw;
    @(negedge clk);
    dec_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    enc_valid_i = 1'b1; enc_data_i = 16'hFFFF;
    dec_valid_i = 1'b1; dec_code_i = 22'h3FFFFF;
    repeat (3) @(negedge clk);
    chk({enc_valid_o, enc_code_o, dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o} == '0,
        "R7 outputs zero in reset", {dec_valid_o, dec_fixed_o, dec_fatal_o}, 0);
    chk(enc_code_o == '0 && dec_data_o == '0, "R7 data zero in reset", dec_data_o, 0);
    enc_valid_i = 1'b0; enc_data_i = '0;
    dec_valid_i = 1'b0; dec_code_i = '0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_encode();
    logic [15:0] pats [5] = '{16'h0000, 16'h0001, 16'h8000, 16'hA5C3, 16'hFFFF};
    foreach (pats[i]) begin
      @(negedge clk);
      enc_valid_i = 1'b1;
      enc_data_i  = pats[i];
      @(negedge clk);
      enc_valid_i = 1'b0;
      chk(enc_valid_o == 1'b1, "R6 encoder valid after one cycle", enc_valid_o, 1);
      chk(enc_code_o == tb_encode(pats[i]), "R1 codeword", enc_code_o, tb_encode(pats[i]));
    end
  endtask

  task automatic t_clean();
    logic [15:0] pats [4] = '{16'h0000, 16'h1234, 16'hBEEF, 16'hFFFF};
    foreach (pats[i]) begin
      dec_run(tb_encode(pats[i]));
      chk(dec_data_o == pats[i], "R2 clean data", dec_data_o, pats[i]);
      chk(!dec_fixed_o && !dec_fatal_o, "R2 clean flags", {dec_fixed_o, dec_fatal_o}, 0);
    end
  endtask

  task automatic t_single();
    logic [15:0] pats [3] = '{16'hA5C3, 16'h0000, 16'hFFFF};
    foreach (pats[i]) begin
      for (int p = 0; p < 22; p++) begin
        dec_run(tb_encode(pats[i]) ^ (22'h1 << p));
        chk(dec_data_o == pats[i], "R3 repaired data", dec_data_o, pats[i]);
        chk(dec_fixed_o && !dec_fatal_o, "R3 flags {fixed,fatal}",
            {dec_fixed_o, dec_fatal_o}, 2'b10);
      end
    end
  endtask

  task automatic t_double();
    logic [21:0] base;
    base = tb_encode(16'h3C96);
    for (int a = 0; a < 22; a++) begin
      for (int b = a + 1; b < 22; b++) begin
        dec_run(base ^ (22'h1 << a) ^ (22'h1 << b));
        chk(dec_fatal_o && !dec_fixed_o, "R4 double flags {fixed,fatal}",
            {dec_fixed_o, dec_fatal_o}, 2'b01);
      end
    end
  endtask

  task automatic t_triple();
    logic [15:0] pats [2] = '{16'h0000, 16'h5A17};
    foreach (pats[i]) begin
      for (int p = 0; p < 20; p++) begin
        dec_run(tb_encode(pats[i]) ^ (22'h7 << p));
        chk(dec_fatal_o && !dec_fixed_o, "R5 adjacent triple flags {fixed,fatal}",
            {dec_fixed_o, dec_fatal_o}, 2'b01);
      end
    end
  endtask

  task automatic t_idle();
    logic [15:0] d;
    d = 16'h6E21;
    dec_run(tb_encode(d) ^ 22'h3);
    chk(dec_valid_o == 1'b1, "R6 decoder valid after one cycle", dec_valid_o, 1);
    chk(dec_fatal_o == 1'b1, "R4 fatal before idle", dec_fatal_o, 1);
    dec_code_i = tb_encode(16'h0000) ^ 22'h1;
    @(negedge clk);
    chk(!dec_valid_o && !dec_fixed_o && !dec_fatal_o, "R8 idle clears valid and flags",
        {dec_valid_o, dec_fixed_o, dec_fatal_o}, 0);
    chk(dec_data_o == (d ^ 16'h0000), "R8 idle holds data", dec_data_o, d);
    @(negedge clk);
    chk(!dec_valid_o, "R6 valid stays low while idle", dec_valid_o, 0);
  endtask

  initial begin
    rst = 1'b1;
    enc_valid_i = 1'b0; enc_data_i = '0;
    dec_valid_i = 1'b0; dec_code_i = '0;
    t_reset();
    t_encode();
    t_clean();
    t_single();
    t_double();
    t_triple();
    t_idle();
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule